// File: doc/BRIEF.md
# Refresh Interval Compare Timer

An 8-bit up-counter paired with a compare register. It paces the refresh requests of a dynamic memory controller. When refresh is switched off, it serves as a general interval timer that raises an interrupt. Each select code from 1 to 7 picks one of seven prescaled clock-enable inputs, and the counter advances on the cycles where that enable is high. Code 0 holds the counter still.

On every count the counter value is compared with the compare register. When they are equal, the counter returns to zero, the sticky match flag is set, and a request goes out. The request is an interrupt when the interrupt enable is set. It is also a one-clock refresh pulse when the refresh enable is set. The interval is therefore compare + 1 counts.

Software configures the block through a single-cycle write port. It can reload the counter at any time, for example writing zero to restart an interval cleanly after changing the compare value.

Top module: `rfsh_interval_timer`

## Requirements
- R1: After reset the counter, compare value, select code, both enables and the flag are zero, and `flag_o`, `irq_o` and `rfsh_o` are low. The counter does not advance, whatever `tick_i` carries.
- R2: Select code 0 stops the counter. A nonzero code k counts only on cycles where `tick_i[k-1]` is high, and all other `tick_i` bits have no effect.
- R3: On a count with the counter equal to the compare value, the counter goes to 0 and `flag_o` is 1 after that clock edge. Otherwise the counter increments. A match therefore occurs on count number compare+1 after the counter is written to 0.
- R4: `irq_o` is registered and equals `flag_o` AND the interrupt enable, both taken as their values after the same clock edge.
- R5: Every match drives `rfsh_o` high for the following cycle when the refresh enable is 1. With the refresh enable at 0, `rfsh_o` stays low.
- R6: A counter above the compare value counts up, wraps from 255 to 0, and matches only when it reaches the compare value again. For example, from 10 with compare 5 the match falls on the 252nd count.
- R7: A counter write in the same cycle as a count takes the written value. That count neither increments the counter nor produces a match.
- R8: The flag holds until a write of 0 to bit 0 of the status address. Writing 1 to that bit has no effect. A match in the same cycle as the clearing write leaves the flag set.
- R9: The write address map is: 0 is the counter, 1 is the compare value, 2 is the control register, and 3 is the status register. The control register layout is bits 2:0 for the select code, bit 3 for the interrupt enable and bit 4 for the refresh enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register address (R9) |
| wr_data | input | 8 | Write data |
| tick_i | input | 7 | Prescaled clock enables; bit k-1 serves select code k |
| flag_o | output | 1 | Sticky compare-match flag |
| irq_o | output | 1 | Interrupt request, flag gated by interrupt enable |
| rfsh_o | output | 1 | One-clock refresh request per match |

## Verification
The assertions assume that the write port carries at most one write per cycle. They therefore assume that a counter reload and a flag clear never occur in the same cycle. They also assume that `tick_i` is a free-running level that needs no relation to the write port. The stimulus drives every write and every tick change at the falling edge, holds each write for exactly one cycle, and deliberately lines up writes with ticks only in the collision cases that R7 and R8 describe.

// File: rtl/rict_pkg.sv
package rict_pkg;
  localparam int ADDR_W      = 2;
  localparam int CTL_IEN_BIT = 3;
  localparam int CTL_REN_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_COUNT = 2'd0,
    RA_LIMIT = 2'd1,
    RA_CTRL  = 2'd2,
    RA_STAT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rict_ctrl_regs.sv
module rict_ctrl_regs
  import rict_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  limit_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              ien_q,
  output logic              ien_nxt,
  output logic              ren_q,
  output logic              cnt_wr,
  output logic              clr_wr
);
  logic ctl_wr;

  always_comb begin
    cnt_wr  = wr_en && (wr_addr == RA_COUNT);
    ctl_wr  = wr_en && (wr_addr == RA_CTRL);
    clr_wr  = wr_en && (wr_addr == RA_STAT) && !wr_data[0];
    ien_nxt = ctl_wr ? wr_data[CTL_IEN_BIT] : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      sel_q   <= '0;
      ien_q   <= 1'b0;
      ren_q   <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == RA_LIMIT)) limit_q <= wr_data;
      if (ctl_wr) begin
        sel_q <= wr_data[SEL_W-1:0];
        ren_q <= wr_data[CTL_REN_BIT];
      end
      ien_q <= ien_nxt;
    end
  end
endmodule

// File: rtl/rict_tick_sel.sv
module rict_tick_sel #(
  parameter int SEL_W = 3,
  localparam int NSRC = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  tick_i,
  output logic             tick_o
);
  logic [NSRC:0] src;

  assign src[0] = 1'b0;
  for (genvar g = 1; g <= NSRC; g++) begin : g_src
    assign src[g] = tick_i[g-1];
  end

  assign tick_o = src[sel];
endmodule

// File: rtl/rict_counter.sv
module rict_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match
);
  logic count_evt;

  always_comb begin
    count_evt = tick && !cnt_wr;
    match     = count_evt && (cnt_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (cnt_wr)    cnt_q <= wr_data;
    else if (match)     cnt_q <= '0;
    else if (count_evt) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rict_event.sv
module rict_event (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic clr_wr,
  input  logic ien_nxt,
  input  logic ren_q,
  output logic flag_q,
  output logic irq_q,
  output logic rfsh_q
);
  logic flag_d;

  always_comb begin
    if (match)       flag_d = 1'b1;
    else if (clr_wr) flag_d = 1'b0;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      rfsh_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & ien_nxt;
      rfsh_q <= match & ren_q;
    end
  end
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
  import rict_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  localparam int NSRC = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [NSRC-1:0]   tick_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              rfsh_o
);
  logic [CNT_W-1:0] limit_q, cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic ien_q, ien_nxt, ren_q, cnt_wr, clr_wr, tick, match;

  rict_ctrl_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .limit_q(limit_q), .sel_q(sel_q), .ien_q(ien_q), .ien_nxt(ien_nxt),
    .ren_q(ren_q), .cnt_wr(cnt_wr), .clr_wr(clr_wr)
  );

  rict_tick_sel #(.SEL_W(SEL_W)) u_sel (
    .sel(sel_q), .tick_i(tick_i), .tick_o(tick)
  );

  rict_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .wr_data(wr_data),
    .limit(limit_q), .cnt_q(cnt_q), .match(match)
  );

  rict_event u_evt (
    .clk(clk), .rst(rst), .match(match), .clr_wr(clr_wr), .ien_nxt(ien_nxt),
    .ren_q(ren_q), .flag_q(flag_o), .irq_q(irq_o), .rfsh_q(rfsh_o)
  );

  // R2: with no source selected the counter only moves on a write
  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_q == '0 && !cnt_wr) |=> $stable(cnt_q));

  // R3: a new flag always coincides with a counter back at zero
  assert_clear_on_match_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> (cnt_q == '0));

  // R4: the request never stands without the flag, and follows it when enabled
  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
  assert_irq_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_o && ien_q) |-> irq_o);

  // R5: a refresh pulse comes only from a match with refresh enabled
  assert_rfsh_gated_R5: assert property (@(posedge clk) disable iff (rst)
    rfsh_o |-> (flag_o && $past(ren_q)));

  // R7: a counter write beats a concurrent count
  assert_write_prio_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr && !flag_o) |=> (!flag_o && cnt_q == $past(wr_data)));

  // R8: the flag is sticky unless cleared by a zero write
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_wr) |=> flag_o);
endmodule

// File: tb/rfsh_interval_timer_bench.sv
module rfsh_interval_timer_bench;
  localparam int NSRC = 7;
  localparam logic [1:0] A_CNT = 2'd0, A_LIM = 2'd1, A_CTL = 2'd2, A_STA = 2'd3;

  typedef struct packed {
    logic [7:0] cmp;
    logic [2:0] sel;
    logic [3:0] gap;
    logic       ie;
    logic       re;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{cmp: 8'd0,   sel: 3'd1, gap: 4'd1, ie: 1'b1, re: 1'b1},
    '{cmp: 8'd7,   sel: 3'd2, gap: 4'd1, ie: 1'b0, re: 1'b1},
    '{cmp: 8'd20,  sel: 3'd4, gap: 4'd3, ie: 1'b1, re: 1'b0},
    '{cmp: 8'd255, sel: 3'd7, gap: 4'd1, ie: 1'b1, re: 1'b1},
    '{cmp: 8'd1,   sel: 3'd5, gap: 4'd2, ie: 1'b0, re: 1'b0},
    '{cmp: 8'd100, sel: 3'd3, gap: 4'd1, ie: 1'b1, re: 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NSRC-1:0] tick_i = '0;
  logic flag_o, irq_o, rfsh_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rfsh_interval_timer u_rfsh_interval_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_i(tick_i), .flag_o(flag_o), .irq_o(irq_o), .rfsh_o(rfsh_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input logic [2:0] sel, input logic ie, input logic re);
    return {3'b000, re, ie, sel};
  endfunction

  // Counts ticks on source sel (every gap cycles) until flag_o is seen; leaves tick_i at 0.
  task automatic run_to_match(input logic [2:0] sel, input int gap, output int n);
    int cyc = 0;
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (flag_o) break;
      if (cyc % gap == 0) begin
        tick_i = NSRC'(1) << (sel - 3'd1);
        n++;
      end else tick_i = '0;
      cyc++;
    end
    tick_i = '0;
  endtask

  task automatic setup(input logic [7:0] cmp, input logic [7:0] cnt);
    wr(A_CTL, 8'h00);
    wr(A_STA, 8'h00);
    wr(A_LIM, cmp);
    wr(A_CNT, cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 flag", flag_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 rfsh", rfsh_o, 0);
    // R1/R2: stopped clock ignores every tick (compare 0 would match at once)
    tick_i = '1;
    repeat (10) @(negedge clk);
    tick_i = '0;
    check("R1 stopped after reset", flag_o, 0);

    // Main table (R3, R4, R5, R9)
    foreach (VECS[i]) begin
      setup(VECS[i].cmp, 8'd0);
      wr(A_CTL, ctl(VECS[i].sel, VECS[i].ie, VECS[i].re));
      run_to_match(VECS[i].sel, int'(VECS[i].gap), n);
      check("R3 counts to match", n, int'(VECS[i].cmp) + 1);
      check("R4 irq at match", irq_o, int'(VECS[i].ie));
      check("R5 rfsh at match", rfsh_o, int'(VECS[i].re));
      @(negedge clk);
      check("R5 rfsh one clock", rfsh_o, 0);
    end

    // R2: other tick bits ignored
    setup(8'd0, 8'd0);
    wr(A_CTL, ctl(3'd3, 1'b0, 1'b0));
    tick_i = 7'h7F & ~7'b0000100;
    repeat (20) @(negedge clk);
    check("R2 foreign ticks ignored", flag_o, 0);
    tick_i = 7'b0000100;
    @(negedge clk);
    tick_i = '0;
    check("R2 own tick counts", flag_o, 1);

    // R6: wrap from above the compare value
    setup(8'd5, 8'd10);
    wr(A_CTL, ctl(3'd1, 1'b0, 1'b1));
    run_to_match(3'd1, 1, n);
    check("R6 wrap count", n, 252);

    // R7: counter write beats a tick in the same cycle
    setup(8'd3, 8'd3);
    wr(A_CTL, ctl(3'd1, 1'b0, 1'b0));
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_CNT; wr_data = 8'd0; tick_i = 7'b0000001;
    @(negedge clk);
    wr_en = 1'b0; tick_i = '0;
    check("R7 no match on write cycle", flag_o, 0);
    run_to_match(3'd1, 1, n);
    check("R7 restarted from zero", n, 4);

    // R8: flag sticky; match beats clear; writing 1 is no-op
    wr(A_LIM, 8'd0);
    wr(A_CNT, 8'd0);
    check("R8 flag held across writes", flag_o, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_STA; wr_data = 8'd0; tick_i = 7'b0000001;
    @(negedge clk);
    wr_en = 1'b0; tick_i = '0;
    check("R8 match wins over clear", flag_o, 1);
    wr(A_STA, 8'h01);
    check("R8 writing one keeps flag", flag_o, 1);
    wr(A_STA, 8'h00);
    check("R8 clear by zero", flag_o, 0);

    // R4: enabling interrupt on a standing flag
    setup(8'd0, 8'd0);
    wr(A_CTL, ctl(3'd1, 1'b0, 1'b0));
    @(negedge clk); tick_i = 7'b0000001;
    @(negedge clk); tick_i = '0;
    check("R4 flag without enable", flag_o, 1);
    check("R4 irq masked", irq_o, 0);
    wr(A_CTL, ctl(3'd0, 1'b1, 1'b0));
    check("R4 irq on enable", irq_o, 1);
    wr(A_STA, 8'h00);
    check("R4 irq drops with flag", irq_o, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule